// File: doc/BRIEF.md
# Shift Unit with Arithmetic-Shift Carry

This block is the shift and bit-manipulation slice of a fixed-point execution pipe. A shift result is produced combinationally from a source operand and a shift amount. The amount is taken either from the low six bits of a second register operand or from a five-bit immediate. Three shift kinds are supported: left logical, right logical and right arithmetic.

The same datapath also produces count-leading-zeros, a per-byte equality mask of two operands, and sign extension of the low byte or low halfword. A single carry flag is registered inside the block. Only a valid arithmetic right shift writes it. The flag records whether a negative source lost any 1 bits during the shift.

Register amounts from 32 to 63 saturate rather than wrap. A logical shift then yields zero. An arithmetic shift yields a copy of the sign bit in every position.

Top module: `shift_unit`

## Requirements
- R1: With op_i = 0 (left logical) or op_i = 1 (right logical) and an amount of 0 to 31, result_o is src_a_i shifted by that amount, with zeros filled in.
- R2: In register mode (use_imm_i = 0) only bits 5:0 of src_b_i form the amount, and higher bits are ignored. When bit 5 is set, both logical shifts give result_o = 0.
- R3: With op_i = 2 (right arithmetic) and an amount of 1 to 31, result_o is src_a_i shifted right with copies of bit 31 filled in.
- R4: A valid arithmetic shift with an amount of 1 to 31 sets carry_o when src_a_i is negative and at least one of the bits shifted out is 1. Otherwise it clears carry_o.
- R5: A register amount with bit 5 set on an arithmetic shift gives all ones for a negative source and zero for a non-negative source. carry_o becomes 1 exactly when the source is negative and any of bits 30:0 is nonzero.
- R6: An amount of zero, from either the immediate or the register, passes src_a_i through unchanged. On a valid arithmetic shift it also clears carry_o.
- R7: carry_o is 0 after reset. It changes only on the clock edge that follows a cycle with valid_i = 1 and op_i = 2, and it holds its value in every other cycle.
- R8: op_i = 3 returns the number of leading zero bits of src_a_i, and returns 32 when src_a_i is zero.
- R9: op_i = 4 sets each result byte to 8'hFF where the matching bytes of src_a_i and src_b_i are equal, and to 8'h00 where they differ.
- R10: op_i = 5 sign-extends src_a_i[7:0]. op_i = 6 sign-extends src_a_i[15:0].
- R11: With use_imm_i = 1 the amount is imm_i (0 to 31), and src_b_i has no effect on shifts.
- R12: op_i = 7 is unassigned and yields result_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation valid; gates the carry update |
| op_i | input | 3 | Operation select (0 SLL, 1 SRL, 2 SRA, 3 CLZ, 4 byte equal, 5 sext byte, 6 sext half, 7 none) |
| src_a_i | input | 32 | Source operand |
| src_b_i | input | 32 | Second operand / register shift amount |
| imm_i | input | 5 | Immediate shift amount |
| use_imm_i | input | 1 | Select immediate amount |
| result_o | output | 32 | Combinational result |
| carry_o | output | 1 | Registered carry flag |

## Verification
result_o is purely combinational, so it is due in the same cycle that the inputs are applied. The bench samples it one time unit after driving the inputs on the falling edge. carry_o lags by one register: it is sampled shortly after the next rising edge, against a model carry updated only for valid arithmetic shifts. The shift amount is swept over every register value from 0 to 63 and every immediate value from 0 to 31, on sign-boundary operand patterns.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;
  typedef enum logic [2:0] {
    OP_SLL  = 3'd0,
    OP_SRL  = 3'd1,
    OP_SRA  = 3'd2,
    OP_CLZ  = 3'd3,
    OP_BEQ  = 3'd4,
    OP_SXB  = 3'd5,
    OP_SXH  = 3'd6,
    OP_NONE = 3'd7
  } su_op_e;
endpackage

// File: rtl/shift_core.sv
module shift_core
  import shift_unit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] src_i,
  input  logic [AMT_W:0]    amt_i,
  input  su_op_e            op_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  logic             big;
  logic [AMT_W-1:0] sh;
  logic             neg;
  logic [DATA_W-1:0] sll_v, srl_v, sra_v, lost_mask;

  assign big = amt_i[AMT_W];
  assign sh  = amt_i[AMT_W-1:0];
  assign neg = src_i[DATA_W-1];

  assign sll_v = big ? '0 : (src_i << sh);
  assign srl_v = big ? '0 : (src_i >> sh);
  assign sra_v = big ? {DATA_W{neg}} : DATA_W'($signed(src_i) >>> sh);

  // saturated amount: only the magnitude bits count toward carry
  assign lost_mask = big ? {1'b0, {(DATA_W-1){1'b1}}}
                         : ((DATA_W'(1) << sh) - DATA_W'(1));
  assign carry_o = neg & (|(src_i & lost_mask));

  always_comb begin
    unique case (op_i)
      OP_SLL:  res_o = sll_v;
      OP_SRL:  res_o = srl_v;
      default: res_o = sra_v;
    endcase
  end
endmodule

// File: rtl/clz_unit.sv
module clz_unit #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DATA_W) + 1
) (
  input  logic [DATA_W-1:0] src_i,
  output logic [CNT_W-1:0]  cnt_o
);
  always_comb begin
    cnt_o = CNT_W'(DATA_W);
    for (int i = 0; i < DATA_W; i++) begin
      if (src_i[i]) cnt_o = CNT_W'(DATA_W - 1 - i);
    end
  end
endmodule

// File: rtl/byte_unit.sv
module byte_unit #(
  parameter int DATA_W = 32,
  parameter int NBYTES = DATA_W / 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] beq_o,
  output logic [DATA_W-1:0] sxb_o,
  output logic [DATA_W-1:0] sxh_o
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    assign beq_o[8*g +: 8] = {8{a_i[8*g +: 8] == b_i[8*g +: 8]}};
  end

  assign sxb_o = {{(DATA_W-8){a_i[7]}}, a_i[7:0]};
  assign sxh_o = {{(DATA_W-16){a_i[15]}}, a_i[15:0]};
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_unit_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W),
  localparam int CNT_W = AMT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [AMT_W-1:0]  imm_i,
  input  logic              use_imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o
);
  su_op_e            op;
  logic [AMT_W:0]    amt;
  logic [DATA_W-1:0] sh_res, beq_res, sxb_res, sxh_res;
  logic [CNT_W-1:0]  clz_cnt;
  logic              sh_carry;
  logic              carry_q;

  assign op  = su_op_e'(op_i);
  assign amt = use_imm_i ? {1'b0, imm_i} : src_b_i[AMT_W:0];

  shift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_shift (
    .src_i   (src_a_i),
    .amt_i   (amt),
    .op_i    (op),
    .res_o   (sh_res),
    .carry_o (sh_carry)
  );

  clz_unit #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_clz (
    .src_i (src_a_i),
    .cnt_o (clz_cnt)
  );

  byte_unit #(.DATA_W(DATA_W)) u_byte (
    .a_i   (src_a_i),
    .b_i   (src_b_i),
    .beq_o (beq_res),
    .sxb_o (sxb_res),
    .sxh_o (sxh_res)
  );

  always_comb begin
    unique case (op)
      OP_SLL, OP_SRL, OP_SRA: result_o = sh_res;
      OP_CLZ:  result_o = DATA_W'(clz_cnt);
      OP_BEQ:  result_o = beq_res;
      OP_SXB:  result_o = sxb_res;
      OP_SXH:  result_o = sxh_res;
      default: result_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       carry_q <= 1'b0;
    else if (valid_i && op == OP_SRA)  carry_q <= sh_carry;
  end

  assign carry_o = carry_q;
endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [DATA_W-1:0] src_a_i,
  input logic [DATA_W-1:0] src_b_i,
  input logic [AMT_W-1:0]  imm_i,
  input logic              use_imm_i,
  input logic [DATA_W-1:0] result_o,
  input logic              carry_o
);
  logic amt_zero;
  logic reg_big;
  assign amt_zero = use_imm_i ? (imm_i == '0) : (src_b_i[AMT_W:0] == '0);
  assign reg_big  = !use_imm_i && src_b_i[AMT_W];

  p_logic_sat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i == 3'd0 || op_i == 3'd1) && reg_big) |-> (result_o == '0));

  p_sra_sat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd2 && reg_big) |-> (result_o == {DATA_W{src_a_i[DATA_W-1]}}));

  p_pos_nocarry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd2 && !src_a_i[DATA_W-1]) |=> !carry_o);

  p_zero_amt_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd2 && amt_zero) |=> !carry_o);

  p_carry_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && op_i == 3'd2) |=> $stable(carry_o));

  p_clz_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd3 && src_a_i == '0) |-> (result_o == DATA_W));
endmodule

bind shift_unit shift_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .src_a_i   (src_a_i),
  .src_b_i   (src_b_i),
  .imm_i     (imm_i),
  .use_imm_i (use_imm_i),
  .result_o  (result_o),
  .carry_o   (carry_o)
);

// File: tb/sim_shift_unit.sv
module sim_shift_unit;
  localparam int P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [31:0] src_a_i = '0;
  logic [31:0] src_b_i = '0;
  logic [4:0]  imm_i = '0;
  logic        use_imm_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic model_c = 1'b0;

  always #(P/2) clk = ~clk;

  shift_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .src_a_i(src_a_i), .src_b_i(src_b_i), .imm_i(imm_i),
    .use_imm_i(use_imm_i), .result_o(result_o), .carry_o(carry_o)
  );

  function automatic logic [31:0] exp_res(int op, logic [31:0] a, logic [31:0] b, int amt);
    logic [31:0] r;
    int n;
    case (op)
      0: r = (amt >= 32) ? 32'h0 : a << amt;
      1: r = (amt >= 32) ? 32'h0 : a >> amt;
      2: r = (amt >= 32) ? {32{a[31]}} : 32'($signed(a) >>> amt);
      3: begin
        n = 0;
        while (n < 32 && a[31-n] == 1'b0) n++;
        r = 32'(n);
      end
      4: for (int k = 0; k < 4; k++) r[8*k +: 8] = (a[8*k +: 8] == b[8*k +: 8]) ? 8'hFF : 8'h00;
      5: r = {{24{a[7]}}, a[7:0]};
      6: r = {{16{a[15]}}, a[15:0]};
      default: r = 32'h0;
    endcase
    return r;
  endfunction

  function automatic logic exp_carry(logic [31:0] a, int amt);
    logic [31:0] lost;
    if (amt == 0) return 1'b0;
    if (amt >= 32) return a[31] && (a[30:0] != 31'h0);
    lost = a % (32'h1 << amt);
    return a[31] && (lost != 32'h0);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(int op, logic [31:0] a, logic [31:0] b, logic [4:0] imm,
                        bit use_imm, bit vld, string tag);
    int amt;
    @(negedge clk);
    op_i = 3'(op); src_a_i = a; src_b_i = b; imm_i = imm;
    use_imm_i = use_imm; valid_i = vld;
    amt = use_imm ? int'(imm) : int'(b[5:0]);
    #1;
    check(tag, result_o, exp_res(op, a, b, amt));
    if (vld && op == 2) model_c = exp_carry(a, amt);
    @(posedge clk);
    #1;
    check((vld && op == 2) ? "R4 carry" : "R7 carry hold", {31'h0, carry_o}, {31'h0, model_c});
  endtask

  function automatic string sh_tag(int op, int amt, bit use_imm);
    if (use_imm) return "R11";
    if (amt == 0) return "R6";
    if (amt >= 32) return (op == 2) ? "R5" : "R2";
    return (op == 2) ? "R3" : "R1";
  endfunction

  logic [31:0] pats [8] = '{32'h0000_0000, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678,
                            32'h8765_4321, 32'h7FFF_FFFF, 32'h8000_0001, 32'h0000_0001};

  initial begin
    #(P * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(P * 3);
    // R7: reset value
    check("R7 reset", {31'h0, carry_o}, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R1 R2 R3 R4 R5 R6: register amounts 0..63, upper src_b bits noise
    foreach (pats[i]) begin
      for (int op = 0; op < 3; op++) begin
        for (int amt = 0; amt < 64; amt++) begin
          run_op(op, pats[i], (32'h5A5A_5A40 & ~32'h3F) | 32'(amt), 5'h1F, 1'b0, 1'b1,
                 sh_tag(op, amt, 1'b0));
        end
      end
    end

    // R11: immediate amounts; src_b carries a conflicting value
    foreach (pats[i]) begin
      for (int op = 0; op < 3; op++) begin
        for (int amt = 0; amt < 32; amt++) begin
          run_op(op, pats[i], 32'h0000_0027, 5'(amt), 1'b1, 1'b1, sh_tag(op, amt, 1'b1));
        end
      end
    end

    // R7: set carry, then non-valid SRA and other ops must not change it
    run_op(2, 32'h8000_0001, 32'h1, 5'h0, 1'b0, 1'b1, "R4");
    check("R4 carry set", {31'h0, carry_o}, 32'h1);
    run_op(2, 32'h0000_0000, 32'h0, 5'h0, 1'b0, 1'b0, "R7");
    run_op(0, 32'h8000_0000, 32'h0, 5'h0, 1'b0, 1'b1, "R7");
    check("R7 carry held", {31'h0, carry_o}, 32'h1);

    // R8: clz on single bits, zero, patterns
    for (int k = 0; k < 32; k++) run_op(3, 32'h1 << k, 32'h0, 5'h0, 1'b0, 1'b1, "R8");
    foreach (pats[i]) run_op(3, pats[i], 32'h0, 5'h0, 1'b0, 1'b1, "R8");

    // R9: byte equality, all 16 match patterns
    for (int m = 0; m < 16; m++) begin
      logic [31:0] b;
      b = 32'hC3A5_5A3C;
      for (int k = 0; k < 4; k++) if (!m[k]) b[8*k +: 8] = ~b[8*k +: 8];
      run_op(4, 32'hC3A5_5A3C, b, 5'h0, 1'b0, 1'b1, "R9");
    end

    // R10 sign extension, R12 unassigned code
    foreach (pats[i]) begin
      run_op(5, pats[i] ^ 32'h0000_0080, 32'h0, 5'h0, 1'b0, 1'b1, "R10");
      run_op(6, pats[i] ^ 32'h0000_8000, 32'h0, 5'h0, 1'b0, 1'b1, "R10");
      run_op(7, pats[i], pats[i], 5'h3, 1'b0, 1'b1, "R12");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule